// File: doc/BRIEF.md
# Data-Transfer Move Executor

This block executes the register and memory move group of a 16-bit fixed-length instruction set with sixteen 32-bit general registers. It holds the register file itself. Each cycle it can accept one instruction word together with that instruction's own address. It decodes the word, forms the effective address, performs at most one access on a single memory port, and writes the results back. Results include sign-extended load data and the adjusted base register of the auto-modify modes.

Moves that need no memory finish in the issue cycle. A move that touches memory raises a registered request one cycle after issue. The request is held until the memory acknowledges, and the block signals completion in the cycle after the acknowledge. A registered observation port lets the surrounding logic read any register. Unaligned accesses, fetch, caches and translation are handled elsewhere. No move here changes the condition flag.

Top module: `xfer_exec`

## Requirements
- R1: After reset every register reads zero, `ins_ready` is 1, and `mem_req` and `done` are 0.
- R2: Word `1110nnnniiiiiiii` writes the sign-extended 8-bit immediate to Rn. Word `0110nnnnmmmm0011` copies Rm to Rn. Both raise `done` one cycle after issue and make no memory request.
- R3: PC-relative loads use PC = instruction address + 4 and zero-extended 8-bit displacements. `1001nnnndddddddd` reads a word at PC + 2·d, sign-extended into Rn. `1101nnnndddddddd` reads a longword at (PC with bits 1:0 cleared) + 4·d into Rn.
- R4: Low bits ss give the access size: 00 byte, 01 word, 10 longword. `mem_size` is one-hot, with bit 0 for byte, bit 1 for word and bit 2 for longword. `0010nnnnmmmm00ss` stores Rm at address Rn, and `0110nnnnmmmm00ss` loads from address Rm into Rn.
- R5: Byte and word loads sign-extend bit 7 or bit 15 of `mem_rdata` into the destination. Longword loads write `mem_rdata` unchanged.
- R6: `0010nnnnmmmm01ss` first lowers Rn by 1, 2 or 4 according to ss and then stores Rm at the new Rn. The stored value is Rm as it stood at issue, even when n equals m.
- R7: `0110nnnnmmmm01ss` loads from address Rm into Rn, then adds 1, 2 or 4 to Rm. When n equals m, the loaded value is kept and no increment is applied.
- R8: Forms with R0 as the data register use a zero-extended 4-bit displacement d and base register field b (bits 7:4). `10000000bbbbdddd` stores a byte at Rb + d, and `10000001bbbbdddd` stores a word at Rb + 2·d. `10000100bbbbdddd` and `10000101bbbbdddd` are the matching loads into R0.
- R9: `0001nnnnmmmmdddd` stores Rm at Rn + 4·d, and `0101nnnnmmmmdddd` loads a longword from Rm + 4·d into Rn.
- R10: `0000nnnnmmmm01ss` stores Rm at address R0 + Rn with size ss.
- R11: `mem_req` rises one cycle after issue and stays high, with address, size and direction unchanged, until `mem_ack`. `ins_ready` is low while the request is pending. `done` is high, and `mem_req` low, in the cycle after the acknowledge.
- R12: Words outside these forms, and ss = 11 in the sized forms, raise `done` one cycle after issue. They make no memory request and change no register.
- R13: Store data is right-aligned on `mem_wdata`. Bits above the access size are zero, and load data is taken from the low bits of `mem_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_valid | input | 1 | Instruction word offered |
| ins_word | input | 16 | Instruction encoding |
| ins_pc | input | 32 | Address of the offered instruction |
| ins_ready | output | 1 | Block can accept an instruction this cycle |
| done | output | 1 | One-cycle pulse when a move has completed |
| mem_req | output | 1 | Memory access pending |
| mem_we | output | 1 | 1 for store, 0 for load |
| mem_size | output | 3 | One-hot size: bit 0 byte, bit 1 word, bit 2 longword |
| mem_addr | output | 32 | Byte address of the access |
| mem_wdata | output | 32 | Right-aligned store data |
| mem_rdata | input | 32 | Right-aligned load data, valid with the acknowledge |
| mem_ack | input | 1 | Memory completes the pending access this cycle |
| obs_sel | input | 4 | Register to observe |
| obs_data | output | 32 | Content of the selected register, one cycle later |

## Verification
Inputs are driven and outputs sampled on the falling edge. An issued word is therefore accepted on the next rising edge. For memory moves, request, address, size and store data are checked at the very next falling edge. For moves without memory, `done` is checked at that same falling edge. For memory moves, `done` and the written registers are due one edge after the acknowledge, and some moves hold the acknowledge back for extra cycles to prove the request is held unchanged. After each move, all sixteen registers are read back through the observation port with its one-cycle latency. They are compared against a reference model in the bench, driven by the same word, PC and returned data.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
  localparam int RIDX = 4;
  localparam int NREG = 1 << RIDX;

  typedef enum logic [2:0] {K_NOP, K_IMM, K_COPY, K_LOAD, K_STORE} kind_t;
  typedef enum logic [1:0] {AB_REG, AB_PC, AB_PCL} abase_t;
  typedef enum logic [1:0] {AO_NONE, AO_DISP, AO_IDX, AO_DEC} aoff_t;
  typedef enum logic [1:0] {UP_NONE, UP_DEC, UP_INC} upd_t;

  typedef logic [1:0] size_t;
  localparam size_t SZ_B = 2'd0;
  localparam size_t SZ_W = 2'd1;
  localparam size_t SZ_L = 2'd2;

  typedef struct packed {
    kind_t            kind;
    size_t            size;
    logic [RIDX-1:0]  ra;    // address base / copy source
    logic [RIDX-1:0]  rd;    // load destination / store source
    abase_t           abase;
    aoff_t            aoff;
    logic [7:0]       disp;  // unscaled, zero-extended later
    upd_t             upd;
    logic [7:0]       imm;
  } dec_t;
endpackage

// File: rtl/xfer_decode.sv
module xfer_decode
  import xfer_pkg::*;
(
  input  logic [15:0] word,
  output dec_t        dec
);
  logic [RIDX-1:0] fn, fm;
  size_t           ss;

  assign fn = word[11:8];
  assign fm = word[7:4];
  assign ss = word[1:0];

  always_comb begin
    dec       = '0;
    dec.kind  = K_NOP;
    dec.abase = AB_REG;
    dec.aoff  = AO_NONE;
    dec.upd   = UP_NONE;
    case (word[15:12])
      4'hE: begin
        dec.kind = K_IMM;
        dec.rd   = fn;
        dec.imm  = word[7:0];
      end
      4'h9: begin
        dec.kind  = K_LOAD;
        dec.size  = SZ_W;
        dec.rd    = fn;
        dec.abase = AB_PC;
        dec.aoff  = AO_DISP;
        dec.disp  = word[7:0];
      end
      4'hD: begin
        dec.kind  = K_LOAD;
        dec.size  = SZ_L;
        dec.rd    = fn;
        dec.abase = AB_PCL;
        dec.aoff  = AO_DISP;
        dec.disp  = word[7:0];
      end
      4'h6: begin
        if (word[3:0] == 4'b0011) begin
          dec.kind = K_COPY;
          dec.rd   = fn;
          dec.ra   = fm;
        end else if (!word[3] && ss != 2'b11) begin
          dec.kind = K_LOAD;
          dec.size = ss;
          dec.rd   = fn;
          dec.ra   = fm;
          dec.upd  = word[2] ? UP_INC : UP_NONE;
        end
      end
      4'h2: begin
        if (!word[3] && ss != 2'b11) begin
          dec.kind = K_STORE;
          dec.size = ss;
          dec.rd   = fm;
          dec.ra   = fn;
          dec.aoff = word[2] ? AO_DEC : AO_NONE;
          dec.upd  = word[2] ? UP_DEC : UP_NONE;
        end
      end
      4'h8: begin
        if (word[11:10] == 2'b00 || word[11:10] == 2'b01) begin
          if (word[9] == 1'b0) begin
            dec.kind = word[10] ? K_LOAD : K_STORE;
            dec.size = word[8] ? SZ_W : SZ_B;
            dec.rd   = '0;
            dec.ra   = fm;
            dec.aoff = AO_DISP;
            dec.disp = {4'h0, word[3:0]};
          end
        end
      end
      4'h1: begin
        dec.kind = K_STORE;
        dec.size = SZ_L;
        dec.rd   = fm;
        dec.ra   = fn;
        dec.aoff = AO_DISP;
        dec.disp = {4'h0, word[3:0]};
      end
      4'h5: begin
        dec.kind = K_LOAD;
        dec.size = SZ_L;
        dec.rd   = fn;
        dec.ra   = fm;
        dec.aoff = AO_DISP;
        dec.disp = {4'h0, word[3:0]};
      end
      4'h0: begin
        if (word[3:2] == 2'b01 && ss != 2'b11) begin
          dec.kind = K_STORE;
          dec.size = ss;
          dec.rd   = fm;
          dec.ra   = fn;
          dec.aoff = AO_IDX;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/xfer_agu.sv
module xfer_agu
  import xfer_pkg::*;
#(
  parameter int DW = 32
) (
  input  abase_t        abase,
  input  aoff_t         aoff,
  input  size_t         size,
  input  logic [7:0]    disp,
  input  logic [DW-1:0] base_reg,
  input  logic [DW-1:0] r0,
  input  logic [DW-1:0] pc,
  output logic [DW-1:0] addr,
  output logic [DW-1:0] inc_val
);
  localparam logic [DW-1:0] PC_STEP = DW'(4);

  logic [DW-1:0] bytes, pc_next, base, off;

  assign bytes   = DW'(1) << size;
  assign pc_next = pc + PC_STEP;

  always_comb begin
    case (abase)
      AB_PC:   base = pc_next;
      AB_PCL:  base = {pc_next[DW-1:2], 2'b00};
      default: base = base_reg;
    endcase
    case (aoff)
      AO_DISP: off = DW'(disp) << size;
      AO_IDX:  off = r0;
      AO_DEC:  off = '0 - bytes;
      default: off = '0;
    endcase
  end

  assign addr    = base + off;
  assign inc_val = base_reg + bytes;
endmodule

// File: rtl/xfer_regfile.sv
module xfer_regfile #(
  parameter int DW   = 32,
  parameter int NREG = 16,
  localparam int RW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [RW-1:0] sel_a,
  input  logic [RW-1:0] sel_b,
  input  logic [RW-1:0] sel_o,
  output logic [DW-1:0] q_a,
  output logic [DW-1:0] q_b,
  output logic [DW-1:0] q_r0,
  output logic [DW-1:0] q_o,
  input  logic          we_p,
  input  logic [RW-1:0] wi_p,
  input  logic [DW-1:0] wd_p,
  input  logic          we_s,
  input  logic [RW-1:0] wi_s,
  input  logic [DW-1:0] wd_s
);
  logic [DW-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)
        regs[g] <= '0;
      else if (we_p && wi_p == RW'(g))
        regs[g] <= wd_p;
      else if (we_s && wi_s == RW'(g))
        regs[g] <= wd_s;
    end
  end

  assign q_a  = regs[sel_a];
  assign q_b  = regs[sel_b];
  assign q_r0 = regs[0];
  assign q_o  = regs[sel_o];
endmodule

// File: rtl/xfer_exec.sv
module xfer_exec
  import xfer_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ins_valid,
  input  logic [15:0]     ins_word,
  input  logic [DW-1:0]   ins_pc,
  output logic            ins_ready,
  output logic            done,
  output logic            mem_req,
  output logic            mem_we,
  output logic [2:0]      mem_size,
  output logic [DW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  input  logic [DW-1:0]   mem_rdata,
  input  logic            mem_ack,
  input  logic [RIDX-1:0] obs_sel,
  output logic [DW-1:0]   obs_data
);
  typedef enum logic {S_IDLE, S_MEM} st_t;

  function automatic logic [DW-1:0] sx(input logic [DW-1:0] v, input size_t s);
    case (s)
      SZ_B:    sx = {{(DW-8){v[7]}}, v[7:0]};
      SZ_W:    sx = {{(DW-16){v[15]}}, v[15:0]};
      default: sx = v;
    endcase
  endfunction

  function automatic logic [DW-1:0] zmask(input logic [DW-1:0] v, input size_t s);
    case (s)
      SZ_B:    zmask = {{(DW-8){1'b0}}, v[7:0]};
      SZ_W:    zmask = {{(DW-16){1'b0}}, v[15:0]};
      default: zmask = v;
    endcase
  endfunction

  st_t             st;
  dec_t            dec;
  logic [DW-1:0]   rf_ra, rf_rd, rf_r0, rf_obs;
  logic [DW-1:0]   ea, inc_val;
  logic            accept, is_mem, fin;
  logic            we_p, we_s;
  logic [RIDX-1:0] wi_p;
  logic [DW-1:0]   wd_p;

  logic            p_load;
  logic [RIDX-1:0] p_rd, p_ra;
  size_t           p_size;
  upd_t            p_upd;
  logic [DW-1:0]   p_newbase;

  xfer_decode u_dec (
    .word (ins_word),
    .dec  (dec)
  );

  xfer_agu #(.DW(DW)) u_agu (
    .abase    (dec.abase),
    .aoff     (dec.aoff),
    .size     (dec.size),
    .disp     (dec.disp),
    .base_reg (rf_ra),
    .r0       (rf_r0),
    .pc       (ins_pc),
    .addr     (ea),
    .inc_val  (inc_val)
  );

  xfer_regfile #(.DW(DW), .NREG(NREG)) u_rf (
    .clk   (clk),
    .rst   (rst),
    .sel_a (dec.ra),
    .sel_b (dec.rd),
    .sel_o (obs_sel),
    .q_a   (rf_ra),
    .q_b   (rf_rd),
    .q_r0  (rf_r0),
    .q_o   (rf_obs),
    .we_p  (we_p),
    .wi_p  (wi_p),
    .wd_p  (wd_p),
    .we_s  (we_s),
    .wi_s  (p_ra),
    .wd_s  (p_newbase)
  );

  assign ins_ready = (st == S_IDLE);
  assign accept    = ins_valid && ins_ready;
  assign is_mem    = (dec.kind == K_LOAD) || (dec.kind == K_STORE);
  assign fin       = (st == S_MEM) && mem_ack;

  // primary write: immediate/copy at issue, load data at completion
  always_comb begin
    we_p = 1'b0;
    wi_p = dec.rd;
    wd_p = rf_ra;
    if (accept && dec.kind == K_IMM) begin
      we_p = 1'b1;
      wd_p = {{(DW-8){dec.imm[7]}}, dec.imm};
    end else if (accept && dec.kind == K_COPY) begin
      we_p = 1'b1;
    end else if (fin && p_load) begin
      we_p = 1'b1;
      wi_p = p_rd;
      wd_p = sx(mem_rdata, p_size);
    end
  end

  // secondary write: base register adjust, dropped when the load owns it
  assign we_s = fin && (p_upd != UP_NONE) && !(p_load && p_ra == p_rd);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      done      <= 1'b0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_size  <= '0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      p_load    <= 1'b0;
      p_rd      <= '0;
      p_ra      <= '0;
      p_size    <= SZ_B;
      p_upd     <= UP_NONE;
      p_newbase <= '0;
      obs_data  <= '0;
    end else begin
      done     <= 1'b0;
      obs_data <= rf_obs;
      case (st)
        S_IDLE: begin
          if (ins_valid) begin
            if (is_mem) begin
              st        <= S_MEM;
              mem_req   <= 1'b1;
              mem_we    <= (dec.kind == K_STORE);
              mem_size  <= 3'b001 << dec.size;
              mem_addr  <= ea;
              mem_wdata <= (dec.kind == K_STORE) ? zmask(rf_rd, dec.size) : '0;
              p_load    <= (dec.kind == K_LOAD);
              p_rd      <= dec.rd;
              p_ra      <= dec.ra;
              p_size    <= dec.size;
              p_upd     <= dec.upd;
              p_newbase <= (dec.upd == UP_DEC) ? ea : inc_val;
            end else begin
              done <= 1'b1;
            end
          end
        end
        S_MEM: begin
          if (mem_ack) begin
            st      <= S_IDLE;
            mem_req <= 1'b0;
            mem_we  <= 1'b0;
            done    <= 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/xfer_exec_chk.sv
module xfer_exec_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          ins_valid,
  input logic          ins_ready,
  input logic          done,
  input logic          mem_req,
  input logic          mem_we,
  input logic [2:0]    mem_size,
  input logic [DW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic          mem_ack
);
  // R11
  hold_req_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_size) && $stable(mem_we));

  // R11
  ack_done_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_ack |=> done && !mem_req);

  // R11
  busy_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !ins_ready);

  // R4
  size_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> $countones(mem_size) == 1);

  // R13
  byte_wdata_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_we && mem_size[0] |-> mem_wdata[DW-1:8] == '0);

  // R2
  issue_resp_chk: assert property (@(posedge clk) disable iff (rst)
    ins_valid && ins_ready |=> done || mem_req);
endmodule

bind xfer_exec xfer_exec_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ins_valid (ins_valid),
  .ins_ready (ins_ready),
  .done      (done),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_size  (mem_size),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .mem_ack   (mem_ack)
);

// File: tb/xfer_exec_bench.sv
`timescale 1ns/1ps
module xfer_exec_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        ins_valid;
  logic [15:0] ins_word;
  logic [31:0] ins_pc;
  logic        ins_ready, done, mem_req, mem_we;
  logic [2:0]  mem_size;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, obs_data;
  logic        mem_ack;
  logic [3:0]  obs_sel;

  always #4 clk = ~clk;

  xfer_exec u_xfer_exec (
    .clk(clk), .rst(rst), .ins_valid(ins_valid), .ins_word(ins_word), .ins_pc(ins_pc),
    .ins_ready(ins_ready), .done(done), .mem_req(mem_req), .mem_we(mem_we),
    .mem_size(mem_size), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack), .obs_sel(obs_sel), .obs_data(obs_data)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 0;
  logic [31:0] rf_ref [16];
  logic        e_mem, e_we;
  logic [1:0]  e_sz;
  logic [31:0] e_addr, e_wdata;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] sxt(input logic [31:0] v, input logic [1:0] s);
    if (s == 2'd0) return {{24{v[7]}}, v[7:0]};
    if (s == 2'd1) return {{16{v[15]}}, v[15:0]};
    return v;
  endfunction

  function automatic logic [31:0] msk(input logic [31:0] v, input logic [1:0] s);
    if (s == 2'd0) return v & 32'hFF;
    if (s == 2'd1) return v & 32'hFFFF;
    return v;
  endfunction

  // reference model built from the requirements
  task automatic ref_model(input logic [15:0] w, input logic [31:0] pc, input logic [31:0] rd);
    int n = int'(w[11:8]);
    int m = int'(w[7:4]);
    logic [1:0]  ss = w[1:0];
    logic [31:0] d4 = {28'd0, w[3:0]};
    logic [31:0] d8 = {24'd0, w[7:0]};
    logic [31:0] pcn = pc + 32'd4;
    logic [31:0] v;
    e_mem = 0; e_we = 0; e_sz = 0; e_addr = 0; e_wdata = 0;
    case (w[15:12])
      4'hE: rf_ref[n] = {{24{w[7]}}, w[7:0]};
      4'h9: begin e_mem = 1; e_sz = 1; e_addr = pcn + d8 * 2; rf_ref[n] = sxt(rd, 1); end
      4'hD: begin e_mem = 1; e_sz = 2; e_addr = {pcn[31:2], 2'b00} + d8 * 4; rf_ref[n] = rd; end
      4'h6: begin
        if (w[3:0] == 4'h3) rf_ref[n] = rf_ref[m];
        else if (w[3:2] == 2'b00 && ss != 3) begin
          e_mem = 1; e_sz = ss; e_addr = rf_ref[m]; rf_ref[n] = sxt(rd, ss);
        end else if (w[3:2] == 2'b01 && ss != 3) begin
          e_mem = 1; e_sz = ss; e_addr = rf_ref[m]; v = sxt(rd, ss);
          if (n != m) rf_ref[m] = rf_ref[m] + (32'd1 << ss);
          rf_ref[n] = v;
        end
      end
      4'h2: begin
        if (w[3:2] == 2'b00 && ss != 3) begin
          e_mem = 1; e_we = 1; e_sz = ss; e_addr = rf_ref[n]; e_wdata = msk(rf_ref[m], ss);
        end else if (w[3:2] == 2'b01 && ss != 3) begin
          e_mem = 1; e_we = 1; e_sz = ss; e_wdata = msk(rf_ref[m], ss);
          rf_ref[n] = rf_ref[n] - (32'd1 << ss); e_addr = rf_ref[n];
        end
      end
      4'h8: begin
        if (w[11:8] == 4'h0 || w[11:8] == 4'h1) begin
          e_mem = 1; e_we = 1; e_sz = {1'b0, w[8]};
          e_addr = rf_ref[m] + (d4 << e_sz); e_wdata = msk(rf_ref[0], e_sz);
        end else if (w[11:8] == 4'h4 || w[11:8] == 4'h5) begin
          e_mem = 1; e_sz = {1'b0, w[8]};
          e_addr = rf_ref[m] + (d4 << e_sz); rf_ref[0] = sxt(rd, e_sz);
        end
      end
      4'h1: begin e_mem = 1; e_we = 1; e_sz = 2; e_addr = rf_ref[n] + d4 * 4; e_wdata = rf_ref[m]; end
      4'h5: begin e_mem = 1; e_sz = 2; e_addr = rf_ref[m] + d4 * 4; rf_ref[n] = rd; end
      4'h0: begin
        if (w[3:2] == 2'b01 && ss != 3) begin
          e_mem = 1; e_we = 1; e_sz = ss; e_addr = rf_ref[0] + rf_ref[n]; e_wdata = msk(rf_ref[m], ss);
        end
      end
      default: ;
    endcase
  endtask

  task automatic verify_regs(input string tag);
    obs_sel = 4'd0;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      check(obs_data === rf_ref[i], tag, $sformatf("R%0d content", i), obs_data, rf_ref[i]);
      obs_sel = 4'(i + 1);
    end
  endtask

  task automatic run_ins(input logic [15:0] w, input logic [31:0] pc, input logic [31:0] rd,
                         input int waits, input string tag);
    logic [31:0] a0;
    ref_model(w, pc, rd);
    @(negedge clk);
    ins_valid = 1; ins_word = w; ins_pc = pc;
    @(negedge clk);
    ins_valid = 0;
    if (e_mem) begin
      check(mem_req === 1'b1, "R11", "request one cycle after issue", 32'(mem_req), 1);
      check(ins_ready === 1'b0, "R11", "ready low while pending", 32'(ins_ready), 0);
      check(mem_addr === e_addr, tag, "address", mem_addr, e_addr);
      check(mem_we === e_we, tag, "direction", 32'(mem_we), 32'(e_we));
      check(mem_size === (3'b001 << e_sz), "R4", "size one-hot", 32'(mem_size), 32'(3'b001 << e_sz));
      if (e_we) check(mem_wdata === e_wdata, "R13", "store data", mem_wdata, e_wdata);
      a0 = mem_addr;
      for (int k = 0; k < waits; k++) begin
        @(negedge clk);
        check(mem_req === 1'b1 && mem_addr === a0, "R11", "request held", mem_addr, a0);
      end
      mem_ack = 1; mem_rdata = rd;
      @(negedge clk);
      mem_ack = 0; mem_rdata = 32'h0;
      check(done === 1'b1 && mem_req === 1'b0, "R11", "done after ack", 32'(done), 1);
    end else begin
      check(done === 1'b1 && mem_req === 1'b0, tag, "done without request", 32'({done, mem_req}), 32'h2);
    end
    verify_regs(tag);
  endtask

  task automatic set_reg(input int n, input logic [31:0] v);
    run_ins({4'h6, 4'(n), 4'(n), 4'h2}, 32'h0, v, 0, "R4");
  endtask

  task automatic t_reset();
    check(ins_ready === 1'b1 && done === 1'b0 && mem_req === 1'b0, "R1", "idle outputs",
          32'({ins_ready, done, mem_req}), 32'h4);
    verify_regs("R1");
  endtask

  task automatic t_imm_copy();
    run_ins(16'hE37F, 32'h0, 0, 0, "R2");
    run_ins(16'hE480, 32'h0, 0, 0, "R2");
    run_ins(16'h6A43, 32'h0, 0, 0, "R2");
  endtask

  task automatic t_pcrel();
    run_ins(16'h9512, 32'h1000, 32'h0000_8001, 0, "R3");
    run_ins(16'hD6FF, 32'h2002, 32'h1234_5678, 0, "R3");
  endtask

  task automatic t_indirect();
    set_reg(1, 32'h100);
    set_reg(2, 32'hCAFE_BABE);
    run_ins(16'h2120, 0, 0, 0, "R4");
    run_ins(16'h2121, 0, 0, 0, "R4");
    run_ins(16'h2122, 0, 0, 0, "R4");
    run_ins(16'h6710, 0, 32'h0000_00F0, 0, "R5");
    run_ins(16'h6711, 0, 32'h0000_7FFF, 0, "R5");
    run_ins(16'h6712, 0, 32'h8000_0000, 0, "R5");
  endtask

  task automatic t_predec();
    run_ins(16'h2124, 0, 0, 0, "R6");
    run_ins(16'h2125, 0, 0, 0, "R6");
    run_ins(16'h2126, 0, 0, 0, "R6");
    run_ins(16'h2114, 0, 0, 0, "R6");
  endtask

  task automatic t_postinc();
    set_reg(8, 32'h200);
    run_ins(16'h6984, 0, 32'h0000_0080, 0, "R7");
    run_ins(16'h6985, 0, 32'h0000_1234, 2, "R7");
    run_ins(16'h6986, 0, 32'hA5A5_0001, 1, "R7");
    run_ins(16'h6886, 0, 32'h0000_0055, 3, "R7");
  endtask

  task automatic t_r0disp();
    set_reg(3, 32'h300);
    set_reg(0, 32'h1122_3344);
    run_ins(16'h8037, 0, 0, 0, "R8");
    run_ins(16'h8135, 0, 0, 0, "R8");
    run_ins(16'h8436, 0, 32'h0000_007F, 0, "R8");
    run_ins(16'h8532, 0, 32'h0000_8000, 0, "R8");
  endtask

  task automatic t_longdisp();
    run_ins(16'h1323, 0, 0, 0, "R9");
    run_ins(16'h5B3F, 0, 32'hDEAD_BEEF, 0, "R9");
  endtask

  task automatic t_index();
    set_reg(0, 32'h10);
    run_ins(16'h0324, 0, 0, 0, "R10");
    run_ins(16'h0325, 0, 0, 0, "R10");
    run_ins(16'h0326, 0, 0, 0, "R10");
  endtask

  task automatic t_unsup();
    run_ins(16'h3000, 0, 0, 0, "R12");
    run_ins(16'h6007, 0, 0, 0, "R12");
    run_ins(16'h2113, 0, 0, 0, "R12");
    run_ins(16'h8200, 0, 0, 0, "R12");
    run_ins(16'h400B, 0, 0, 0, "R12");
  endtask

  initial begin
    for (int i = 0; i < 16; i++) rf_ref[i] = 32'h0;
    rst = 1; ins_valid = 0; ins_word = 0; ins_pc = 0;
    mem_rdata = 0; mem_ack = 0; obs_sel = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_imm_copy();
    t_pcrel();
    t_indirect();
    t_predec();
    t_postinc();
    t_r0disp();
    t_longdisp();
    t_index();
    t_unsup();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog run did not complete actual=%h expected=%h", 32'd0, 32'd1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule